// File: doc/BRIEF.md
# Stereo Volume and Soft-Mute Stage

This block is the gain stage of a stereo PCM audio path. Each channel carries a 20-bit two's-complement sample, and a single valid strobe qualifies both channels. The left and right channels each have their own 8-bit attenuation code. The code maps to a linear coefficient along a piecewise law. The law has quarter-decibel steps near full scale, then whole-decibel steps, then one isolated deep setting, and finally a hard cut to silence. The coefficient multiplies the sample, and the product is rounded back to the sample width.

A soft mute sits on top of the volume. It does not silence the channels at once. It scales both channels by a raised-cosine factor that moves one step per sample, so full gain fades to zero over 32 samples. A mute request can come from an external pin or from a control bit. A mute is also forced while the upstream receiver reports that it has lost lock, unless an override bit is set. If the request drops before the fade completes, or while it is running in either direction, the fade turns back from its current step.

Both attenuation codes are sampled on the strobe. The result leaves the block two clock cycles later. This keeps every output sample computed from one consistent pair of coefficients.

Top module: `stereo_gain_mute`

## Requirements
- R1: With attenuation code 0 and no mute in progress, each output sample equals its input sample exactly.
- R2: Codes 0 to 200 select an attenuation of 0.25 dB times the code. Each code's coefficient is G = round(32768 x 10^(-dB/20)). The ramp factor F and the sample S combine as C = (G x F + 16384) >> 15, and the output is (S x C + 16384) >>> 15 (arithmetic shift).
- R3: Codes 201 to 210 select an attenuation of 50 + (code - 200) dB, that is 51 to 60 dB, using the same arithmetic as R2.
- R4: Code 211 selects 66 dB of attenuation. Every code from 212 to 255 forces that channel's output to zero.
- R5: The left code affects only the left output, and the right code affects only the right output.
- R6: Each input strobe produces exactly one output-valid pulse, two clock cycles after the strobe cycle. Output-valid is low at all other times.
- R7: An attenuation code is used only when the strobe is present. A code change in the cycles after a strobe does not alter the output for that strobe.
- R8: A high mute pin or a set mute control bit each request a mute on their own.
- R9: A low lock input requests a mute when the lock-override bit is clear. When the override bit is set, the lock input has no effect.
- R10: The ramp position p runs from 0 to 32 and starts at 0 after reset. A strobe uses F = round(32768 x (1 + cos(pi x p / 32)) / 2) for the current p. While a mute is requested, p then rises by one per strobe and stops at 32, which gives zero output.
- R11: While no mute is requested, p falls by one per strobe and stops at 0. A change of request in the middle of a ramp turns the ramp back from the current p.
- R12: During and right after reset, output-valid is low, both outputs are zero, and p is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Strobe that qualifies both input samples |
| inL | input | 20 | Left input sample, two's complement |
| inR | input | 20 | Right input sample, two's complement |
| volL | input | 8 | Left attenuation code |
| volR | input | 8 | Right attenuation code |
| mutePin | input | 1 | External mute request |
| muteReg | input | 1 | Control-bit mute request |
| lockIn | input | 1 | Upstream receiver lock indication, high when locked |
| lockOverride | input | 1 | When set, a loss of lock does not force a mute |
| validOut | output | 1 | Output samples valid |
| outL | output | 20 | Left output sample |
| outR | output | 20 | Right output sample |

## Verification
Some properties are checked on every cycle. The ramp position moves by at most one step and only on a strobe. It climbs whenever a pin, control-bit or loss-of-lock request is active, and it falls when no request is active. It never passes its end point. Every strobe gives exactly one valid pulse two cycles later, a cut code always gives zero, and a unity code with no ramp applied passes the sample unchanged.

Other behaviour can only be shown by the bench's scenarios. These cover the exact rounded values along the fine, coarse and deep parts of the attenuation law, and the separation between left and right. They also cover the proof that a code changed after the strobe is ignored, and the full cosine fade, including a turn-back in the middle of a ramp.

// File: rtl/sgm_pkg.sv
package sgm_pkg;

  localparam int CODE_W      = 8;
  localparam int COEF_W      = 16;
  localparam int COEF_FRAC   = COEF_W - 1;
  localparam int FINE_LAST   = 200;
  localparam int COARSE_LAST = 210;
  localparam int DEEP_CODE   = 211;
  localparam int CUT_CODE    = 212;
  localparam int DEEP_DB     = 66;
  localparam int FINE_BASE_DB = 50;

  typedef struct packed {
    logic              load;
    logic [COEF_W-1:0] rampGain;
  } sgm_strobe_t;

  function automatic real fracScale(input int bits);
    real s;
    s = 1.0;
    for (int i = 0; i < bits; i++) s = s * 2.0;
    return s;
  endfunction

  // exp(x) for x >= 0 by a long Taylor sum
  function automatic real expPos(input real x);
    real term;
    real sum;
    term = 1.0;
    sum  = 1.0;
    for (int n = 1; n < 80; n++) begin
      term = term * x / n;
      sum  = sum + term;
    end
    return sum;
  endfunction

  // cos(x) for 0 <= x <= pi
  function automatic real cosSeries(input real x);
    real term;
    real sum;
    term = 1.0;
    sum  = 1.0;
    for (int n = 1; n < 30; n++) begin
      term = -term * x * x / ((2 * n - 1) * (2 * n));
      sum  = sum + term;
    end
    return sum;
  endfunction

  function automatic real codeToDb(input int code);
    if (code <= FINE_LAST)        return code * 0.25;
    else if (code <= COARSE_LAST) return FINE_BASE_DB + (code - FINE_LAST);
    else                          return DEEP_DB;
  endfunction

  function automatic logic [COEF_W-1:0] gainCoef(input int code);
    real lin;
    if (code >= CUT_CODE) return '0;
    lin = 1.0 / expPos(codeToDb(code) * 2.302585092994046 / 20.0);
    return COEF_W'($rtoi(lin * fracScale(COEF_FRAC) + 0.5));
  endfunction

  function automatic logic [COEF_W-1:0] rampCoef(input int pos, input int steps);
    real c;
    c = cosSeries(3.141592653589793 * pos / steps);
    return COEF_W'($rtoi(fracScale(COEF_FRAC) * (1.0 + c) / 2.0 + 0.5));
  endfunction

endpackage

// File: rtl/sgm_gain_lut.sv
module sgm_gain_lut
  import sgm_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [COEF_W-1:0] coef
);

  localparam int NUM_CODES = CUT_CODE;

  logic [COEF_W-1:0] coefTab [NUM_CODES];
  logic [CODE_W-1:0] idx;
  logic              isCut;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_tab
    localparam logic [COEF_W-1:0] ENTRY = gainCoef(i);
    assign coefTab[i] = ENTRY;
  end

  assign isCut = (int'(code) >= CUT_CODE);
  assign idx   = isCut ? '0 : code;

  always_comb begin
    if (isCut) coef = '0;
    else       coef = coefTab[idx];
  end

endmodule

// File: rtl/sgm_ramp_ctrl.sv
module sgm_ramp_ctrl
  import sgm_pkg::*;
#(
  parameter int RAMP_STEPS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic        mutePin,
  input  logic        muteReg,
  input  logic        lockIn,
  input  logic        lockOverride,
  output sgm_strobe_t strobe
);

  localparam int POS_W = $clog2(RAMP_STEPS + 1);
  localparam logic [POS_W-1:0] POS_END = POS_W'(RAMP_STEPS);

  logic [COEF_W-1:0] rampTab [RAMP_STEPS + 1];
  logic [POS_W-1:0]  rampPos;
  logic              muteReq;
  logic              lockMute;

  for (genvar p = 0; p <= RAMP_STEPS; p++) begin : g_ramp
    localparam logic [COEF_W-1:0] ENTRY = rampCoef(p, RAMP_STEPS);
    assign rampTab[p] = ENTRY;
  end

  assign lockMute = !lockIn && !lockOverride;
  assign muteReq  = mutePin || muteReg || lockMute;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rampPos <= '0;
    end else if (validIn) begin
      if (muteReq && rampPos != POS_END)     rampPos <= rampPos + 1'b1;
      else if (!muteReq && rampPos != '0)    rampPos <= rampPos - 1'b1;
    end
  end

  assign strobe.load     = validIn;
  assign strobe.rampGain = rampTab[rampPos];

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(rampPos));

  a_r10_bound: assert property (@(posedge clk) disable iff (!rstN)
    rampPos <= POS_END);

  a_r8_pin_fades: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && mutePin && rampPos != POS_END) |=> rampPos == $past(rampPos) + 1'b1);

  a_r8_reg_fades: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && muteReg && rampPos != POS_END) |=> rampPos == $past(rampPos) + 1'b1);

  a_r9_lock_fades: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !lockIn && !lockOverride && rampPos != POS_END)
      |=> rampPos == $past(rampPos) + 1'b1);

  a_r11_unmute_back: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !mutePin && !muteReg && (lockIn || lockOverride) && rampPos != '0)
      |=> rampPos == $past(rampPos) - 1'b1);

endmodule

// File: rtl/sgm_datapath.sv
module sgm_datapath
  import sgm_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  sgm_strobe_t                  strobe,
  input  logic [1:0][DATA_W-1:0]       sampleIn,
  input  logic [1:0][CODE_W-1:0]       codeIn,
  output logic                         validOut,
  output logic [1:0][DATA_W-1:0]       sampleOut
);

  localparam int MIX_W  = 2 * COEF_W;
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam logic [MIX_W-1:0]         MIX_RND  = MIX_W'(1) << (COEF_FRAC - 1);
  localparam logic signed [PROD_W-1:0] PROD_RND = PROD_W'(1) << (COEF_FRAC - 1);
  localparam logic [COEF_W-1:0]        UNITY    = COEF_W'(1) << COEF_FRAC;

  logic                      stageValid;
  logic [1:0][DATA_W-1:0]    sampleQ;
  logic [1:0][COEF_W-1:0]    gainQ;
  logic [1:0][COEF_W-1:0]    lutCoef;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    sgm_gain_lut u_lut (
      .code (codeIn[c]),
      .coef (lutCoef[c])
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sampleQ[c] <= '0;
        gainQ[c]   <= '0;
      end else if (strobe.load) begin
        sampleQ[c] <= sampleIn[c];
        gainQ[c]   <= COEF_W'((MIX_W'(lutCoef[c]) * MIX_W'(strobe.rampGain) + MIX_RND)
                              >> COEF_FRAC);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sampleOut[c] <= '0;
      end else if (stageValid) begin
        sampleOut[c] <= DATA_W'((PROD_W'($signed(sampleQ[c])) *
                                 PROD_W'($signed({1'b0, gainQ[c]})) + PROD_RND)
                                >>> COEF_FRAC);
      end
    end

    a_r4_cut_silent: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && int'(codeIn[c]) >= CUT_CODE) |=> ##1 (sampleOut[c] == '0));

    a_r1_unity_pass: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && codeIn[c] == '0 && strobe.rampGain == UNITY)
        |=> ##1 (sampleOut[c] == $past(sampleIn[c], 2)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      validOut   <= 1'b0;
    end else begin
      stageValid <= strobe.load;
      validOut   <= stageValid;
    end
  end

  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ##1 validOut);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ##1 !validOut);

endmodule

// File: rtl/stereo_gain_mute.sv
module stereo_gain_mute
  import sgm_pkg::*;
#(
  parameter int DATA_W     = 20,
  parameter int RAMP_STEPS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [DATA_W-1:0] inL,
  input  logic [DATA_W-1:0] inR,
  input  logic [CODE_W-1:0] volL,
  input  logic [CODE_W-1:0] volR,
  input  logic              mutePin,
  input  logic              muteReg,
  input  logic              lockIn,
  input  logic              lockOverride,
  output logic              validOut,
  output logic [DATA_W-1:0] outL,
  output logic [DATA_W-1:0] outR
);

  sgm_strobe_t            strobe;
  logic [1:0][DATA_W-1:0] sampleOut;

  sgm_ramp_ctrl #(
    .RAMP_STEPS (RAMP_STEPS)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .validIn      (validIn),
    .mutePin      (mutePin),
    .muteReg      (muteReg),
    .lockIn       (lockIn),
    .lockOverride (lockOverride),
    .strobe       (strobe)
  );

  sgm_datapath #(
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sampleIn  ({inR, inL}),
    .codeIn    ({volR, volL}),
    .validOut  (validOut),
    .sampleOut (sampleOut)
  );

  assign outL = sampleOut[0];
  assign outR = sampleOut[1];

endmodule

// File: tb/stereo_gain_mute_bench.sv
module stereo_gain_mute_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        validIn;
  logic [19:0] inL, inR;
  logic [7:0]  volL, volR;
  logic        mutePin, muteReg, lockIn, lockOverride;
  logic        validOut;
  logic [19:0] outL, outR;

  int checks = 0;
  int fails  = 0;
  int bPos   = 0;

  always #5 clk = ~clk;

  stereo_gain_mute u_stereo_gain_mute (
    .clk (clk), .rstN (rstN), .validIn (validIn),
    .inL (inL), .inR (inR), .volL (volL), .volR (volR),
    .mutePin (mutePin), .muteReg (muteReg),
    .lockIn (lockIn), .lockOverride (lockOverride),
    .validOut (validOut), .outL (outL), .outR (outR)
  );

  function automatic longint bGain(input int code);
    real db;
    if (code >= 212) return 0;
    if (code <= 200)      db = code * 0.25;
    else if (code <= 210) db = 50.0 + (code - 200);
    else                  db = 66.0;
    return longint'($rtoi(32768.0 * (10.0 ** (-db / 20.0)) + 0.5));
  endfunction

  function automatic longint bRamp(input int p);
    return longint'($rtoi(32768.0 * (1.0 + $cos(3.141592653589793 * p / 32.0)) / 2.0 + 0.5));
  endfunction

  function automatic longint bOut(input longint s, input int code, input int p);
    longint comb;
    comb = (bGain(code) * bRamp(p) + 16384) >> 15;
    return (s * comb + 16384) >>> 15;
  endfunction

  function automatic longint sx(input logic [19:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one strobe, check R6 timing and both outputs
  task automatic sendSample(input logic [19:0] sl, input logic [19:0] sr,
                            input int vl, input int vr, input bit alterAfter,
                            input string req);
    longint eL, eR;
    bit mreq;
    @(negedge clk);
    check(validOut == 1'b0, "R6 idle", longint'(validOut), 0);
    inL = sl; inR = sr; volL = 8'(vl); volR = 8'(vr); validIn = 1'b1;
    mreq = mutePin || muteReg || (!lockIn && !lockOverride);
    eL = bOut(sx(sl), vl, bPos);
    eR = bOut(sx(sr), vr, bPos);
    if (mreq && bPos < 32) bPos++;
    else if (!mreq && bPos > 0) bPos--;
    @(negedge clk);
    validIn = 1'b0;
    if (alterAfter) begin
      volL = ~volL; volR = ~volR; inL = ~inL; inR = ~inR;
    end
    check(validOut == 1'b0, "R6 early", longint'(validOut), 0);
    @(negedge clk);
    check(validOut == 1'b1, "R6 pulse", longint'(validOut), 1);
    check(sx(outL) == eL, {req, " left"}, sx(outL), eL);
    check(sx(outR) == eR, {req, " right"}, sx(outR), eR);
  endtask

  function automatic logic [19:0] rndSample();
    return 20'($urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; validIn = 1'b0; inL = '0; inR = '0; volL = '0; volR = '0;
    mutePin = 1'b0; muteReg = 1'b0; lockIn = 1'b1; lockOverride = 1'b0;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(validOut == 1'b0, "R12 valid", longint'(validOut), 0);
    check(outL == '0 && outR == '0, "R12 outputs", sx(outL), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(validOut == 1'b0, "R12 after release", longint'(validOut), 0);

    // R1 passthrough incl. extremes; also proves ramp starts at p=0 (R12)
    sendSample(20'h7FFFF, 20'h80000, 0, 0, 1'b0, "R1");
    sendSample(20'h00001, 20'hFFFFF, 0, 0, 1'b0, "R1");
    for (int i = 0; i < 20; i++) sendSample(rndSample(), rndSample(), 0, 0, 1'b0, "R1");

    // R2 fine steps
    sendSample(20'h7FFFF, 20'h80000, 1, 200, 1'b0, "R2");
    for (int i = 0; i < 40; i++)
      sendSample(rndSample(), rndSample(), int'($urandom_range(200)), int'($urandom_range(200)),
                 1'b0, "R2");

    // R3 coarse steps
    for (int c = 201; c <= 210; c++) sendSample(20'h7FFFF, 20'h80000, c, c, 1'b0, "R3");

    // R4 deep setting and cut
    sendSample(20'h7FFFF, 20'h80000, 211, 211, 1'b0, "R4");
    sendSample(20'h7FFFF, 20'h80000, 212, 255, 1'b0, "R4");
    sendSample(rndSample(), rndSample(), 230, 213, 1'b0, "R4");

    // R5 independent channels
    sendSample(20'h40000, 20'h40000, 0, 255, 1'b0, "R5");
    sendSample(20'h40000, 20'h40000, 255, 0, 1'b0, "R5");
    sendSample(20'h40000, 20'h40000, 40, 120, 1'b0, "R5");

    // R7 codes and samples changed after the strobe are ignored
    sendSample(20'h3ABCD, 20'hC1234, 0, 8, 1'b1, "R7");
    sendSample(20'h12345, 20'h6789A, 100, 205, 1'b1, "R7");

    // R8 pin mute full fade, then R11 release
    mutePin = 1'b1;
    for (int i = 0; i < 36; i++) sendSample(rndSample(), rndSample(), 0, 12, 1'b0, "R8 R10 pin");
    mutePin = 1'b0;
    for (int i = 0; i < 36; i++) sendSample(rndSample(), rndSample(), 0, 12, 1'b0, "R11 release");

    // R8 register mute, reversed mid-ramp (R11)
    muteReg = 1'b1;
    for (int i = 0; i < 10; i++) sendSample(20'h7FFFF, 20'h80000, 0, 0, 1'b0, "R8 R10 reg");
    muteReg = 1'b0;
    for (int i = 0; i < 4; i++) sendSample(20'h7FFFF, 20'h80000, 0, 0, 1'b0, "R11 reverse");
    muteReg = 1'b1;
    for (int i = 0; i < 3; i++) sendSample(20'h7FFFF, 20'h80000, 0, 0, 1'b0, "R11 re-mute");
    muteReg = 1'b0;
    for (int i = 0; i < 12; i++) sendSample(20'h7FFFF, 20'h80000, 0, 0, 1'b0, "R11 back");

    // R9 loss of lock with and without override
    lockIn = 1'b0;
    lockOverride = 1'b1;
    for (int i = 0; i < 5; i++) sendSample(20'h7FFFF, 20'h80000, 0, 0, 1'b0, "R9 override");
    lockOverride = 1'b0;
    for (int i = 0; i < 34; i++) sendSample(20'h50000, 20'hB0000, 0, 0, 1'b0, "R9 unlock");
    lockIn = 1'b1;
    for (int i = 0; i < 34; i++) sendSample(20'h50000, 20'hB0000, 0, 0, 1'b0, "R9 relock");

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      mutePin      = ($urandom_range(9) == 0);
      muteReg      = ($urandom_range(9) == 0);
      lockIn       = ($urandom_range(7) != 0);
      lockOverride = ($urandom_range(3) == 0);
      sendSample(rndSample(), rndSample(), int'($urandom_range(255)),
                 int'($urandom_range(255)), 1'($urandom_range(1)), "R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule